// File: doc/BRIEF.md
# Network Request Parser and Checker

This block receives remote memory access requests from the network side, one 512-bit beat per cycle. Every packet opens with a start-of-packet cell that names the target node and the source node. The next beat holds a 16-byte request descriptor followed by up to 48 bytes of payload. Any further beats carry 64 payload bytes each, so the largest payload of 496 bytes fills eight forwarded beats. The parser removes the start-of-packet beat and checks the descriptor. It then passes the packet through with one register stage to one of three consumers: the memory path, the configuration register path, or the checkpoint/restart unit.

Forwarding is cut-through, so the accept-or-drop decision is made on the descriptor beat. When a packet is dropped, the rest of its beats are consumed silently up to its last beat. A saturating drop counter, the reason code and the source node of the last dropped packet are held on debug outputs. An accepted read takes the lowest free slot of a small tag table. That slot keeps the source node, the requester tag, the address and the length, which the response logic reads back and frees later. When the table is full, a read that passes its checks is held back through `in_ready`, so it is never dropped. An accepted request whose notify bit is set raises a one-cycle notification to its requester.

Top module: `np_request_parser`

## Requirements
- R1: After reset, `out_valid` and `notify_valid` are 0, `in_ready` is 1, `dbg_drop_cnt` is 0, and no tag slot is valid.
- R2: Beats are taken only after a beat flagged `in_sop`, and that start-of-packet beat never reaches the output. In the start-of-packet beat, bits [NODE_W-1:0] hold the destination and bits [32+NODE_W-1:32] hold the source. The descriptor beat appears on the output with `out_first`=1 in the cycle after it is accepted. A stray beat without `in_sop`, or a start-of-packet beat that also carries `in_eop`, produces no output and no drop.
- R3: Each accepted beat of a passing packet appears unchanged on `out_data` one cycle after acceptance, and `out_last` copies `in_eop`.
- R4: The descriptor command field, bits [3:0], selects the target. Commands 1 (memory write) and 2 (memory read) go to target 0. Commands 3 and 4 (configuration write and read) go to target 1. Command 5 (checkpoint) goes to target 2. The target holds for every beat of the packet.
- R5: A destination other than the NODE_ID parameter drops the packet with reason 1. This check has the highest priority.
- R6: A command outside 1..5, or a nonzero reserved field in bits [7:5], drops the packet with reason 2.
- R7: The address field, bits [95:32], is rejected with reason 3 when its low 4 bits are not zero or when any bit at or above ADDR_W is set.
- R8: The length field, bits [31:16], is rejected with reason 4 when it is zero, not a multiple of 16, or above MAX_LEN. The checks rank destination, then command, then address, then length.
- R9: A dropped packet produces no output beat up to and including its last beat. The drop increments `dbg_drop_cnt` and latches the reason and the source node. The next packet is handled normally.
- R10: An accepted read (command 2) takes the lowest free tag slot, and `out_tag` shows that slot on the first beat. A lookup of that slot returns valid, the source node, the requester tag (bits [15:8]), the address and the length.
- R11: While every tag slot is taken, a read that passes its checks is stalled with `in_ready`=0 and nothing is forwarded. It is accepted once a slot is freed. Other commands and failing reads are not stalled.
- R12: An accepted packet with the notify bit (bit 4) set pulses `notify_valid` for one cycle, together with its first output beat. The pulse carries the source node and the requester tag. Dropped packets never notify.
- R13: A pulse on `tag_free_valid` clears the named slot, and that slot becomes the next one handed out when it is the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sop | input | 1 | Beat is the start-of-packet cell |
| in_eop | input | 1 | Last beat of the packet |
| in_data | input | DATA_W | Input beat |
| out_valid | output | 1 | Forwarded beat valid |
| out_first | output | 1 | Forwarded beat is the descriptor beat |
| out_last | output | 1 | Forwarded beat ends the packet |
| out_target | output | 2 | 0 memory, 1 configuration, 2 checkpoint |
| out_tag | output | $clog2(TAG_DEPTH) | Tag slot of an accepted read, on the first beat |
| out_data | output | DATA_W | Forwarded beat |
| notify_valid | output | 1 | Notification pulse |
| notify_node | output | NODE_W | Requester node for the notification |
| notify_rtag | output | 8 | Requester tag for the notification |
| tag_free_valid | input | 1 | Release a tag slot |
| tag_free_idx | input | $clog2(TAG_DEPTH) | Slot to release |
| tag_look_idx | input | $clog2(TAG_DEPTH) | Slot to read back |
| tag_look_valid | output | 1 | Read-back slot is occupied |
| tag_look_node | output | NODE_W | Stored source node |
| tag_look_rtag | output | 8 | Stored requester tag |
| tag_look_addr | output | ADDR_W | Stored address |
| tag_look_len | output | 16 | Stored length in bytes |
| dbg_drop_cnt | output | CNT_W | Saturating count of dropped packets |
| dbg_reason | output | 3 | Reason for the last drop |
| dbg_node | output | NODE_W | Source node of the last dropped packet |

## Verification
A corrupted packet state shows up within one beat. Either a body beat leaks out during a drop, or a descriptor beat arrives without `out_first`. Either way it is visible on the very next cycle. A wrong check or a wrong check priority shows up right after the descriptor beat, as a missing forward or a drop counter and reason that differ from the values worked out in the bench. The sweeps cover every command code, every length from 0 to 520, and every low address nibble. A broken tag table shows up at the next read. It appears as a wrong `out_tag`, a wrong lookup value, or a stall that never clears after a slot is freed.

// File: rtl/np_pkg.sv
package np_pkg;

   typedef enum logic [1:0] {
      TGT_MEM  = 2'd0,
      TGT_CFG  = 2'd1,
      TGT_CKPT = 2'd2,
      TGT_NONE = 2'd3
   } target_e;

   typedef enum logic [2:0] {
      RSN_NONE = 3'd0,
      RSN_DEST = 3'd1,
      RSN_CMD  = 3'd2,
      RSN_ADDR = 3'd3,
      RSN_LEN  = 3'd4
   } reason_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DESC = 2'd1,
      ST_BODY = 2'd2,
      ST_DROP = 2'd3
   } pstate_e;

   localparam logic [3:0] CMD_MEM_WR  = 4'd1;
   localparam logic [3:0] CMD_MEM_RD  = 4'd2;
   localparam logic [3:0] CMD_CFG_WR  = 4'd3;
   localparam logic [3:0] CMD_CFG_RD  = 4'd4;
   localparam logic [3:0] CMD_CKPT    = 4'd5;

   localparam int DESC_USED_W = 96;
   localparam int RTAG_W      = 8;
   localparam int LEN_W       = 16;
   localparam int GRAN_LOG    = 4;
   localparam int SRC_LSB     = 32;

endpackage

// File: rtl/np_desc_check.sv
module np_desc_check
   import np_pkg::*;
#(
   parameter int NODE_W = 16,
   parameter int ADDR_W = 48,
   parameter logic [NODE_W-1:0] NODE_ID = NODE_W'(7),
   parameter int MAX_LEN = 496
) (
   input  logic [DESC_USED_W-1:0] desc,
   input  logic [NODE_W-1:0]      dest,
   output logic                   ok,
   output reason_e                reason,
   output target_e                target,
   output logic                   is_read,
   output logic                   notify,
   output logic [RTAG_W-1:0]      rtag,
   output logic [LEN_W-1:0]       len,
   output logic [ADDR_W-1:0]      addr
);

   localparam logic [LEN_W-1:0] MAX_LEN_L = LEN_W'(MAX_LEN);

   logic [3:0]  cmd;
   logic [2:0]  rsvd;
   logic [63:0] addr_full;
   logic        cmd_known;
   logic        addr_hi_bad;
   logic        len_bad;

   assign cmd       = desc[3:0];
   assign notify    = desc[4];
   assign rsvd      = desc[7:5];
   assign rtag      = desc[15:8];
   assign len       = desc[31:16];
   assign addr_full = desc[95:32];
   assign addr      = addr_full[ADDR_W-1:0];

   if (ADDR_W < 64) begin : g_addr_narrow
      assign addr_hi_bad = |addr_full[63:ADDR_W];
   end else begin : g_addr_full
      assign addr_hi_bad = 1'b0;
   end

   always_comb begin
      cmd_known = 1'b1;
      target    = TGT_NONE;
      case (cmd)
         CMD_MEM_WR, CMD_MEM_RD: target = TGT_MEM;
         CMD_CFG_WR, CMD_CFG_RD: target = TGT_CFG;
         CMD_CKPT:               target = TGT_CKPT;
         default:                cmd_known = 1'b0;
      endcase
   end

   assign is_read = (cmd == CMD_MEM_RD);
   assign len_bad = (len == '0) || (len[GRAN_LOG-1:0] != '0) || (len > MAX_LEN_L);

   always_comb begin
      if (dest != NODE_ID)                               reason = RSN_DEST;
      else if (!cmd_known || rsvd != 3'b000)             reason = RSN_CMD;
      else if (addr_full[GRAN_LOG-1:0] != '0 || addr_hi_bad) reason = RSN_ADDR;
      else if (len_bad)                                  reason = RSN_LEN;
      else                                               reason = RSN_NONE;
   end

   assign ok = (reason == RSN_NONE);

endmodule

// File: rtl/np_tag_map.sv
module np_tag_map #(
   parameter int DEPTH  = 8,
   parameter int NODE_W = 16,
   parameter int ADDR_W = 48,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [NODE_W-1:0] alloc_node,
   input  logic [7:0]        alloc_rtag,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [15:0]       alloc_len,
   output logic [IDX_W-1:0]  alloc_idx,
   output logic              full,
   input  logic              free_en,
   input  logic [IDX_W-1:0]  free_idx,
   input  logic [IDX_W-1:0]  look_idx,
   output logic              look_valid,
   output logic [NODE_W-1:0] look_node,
   output logic [7:0]        look_rtag,
   output logic [ADDR_W-1:0] look_addr,
   output logic [15:0]       look_len
);

   typedef struct packed {
      logic [NODE_W-1:0] node;
      logic [7:0]        rtag;
      logic [ADDR_W-1:0] addr;
      logic [15:0]       len;
   } entry_t;

   logic [DEPTH-1:0] valid_q;
   entry_t           ent_q [DEPTH];

   always_comb begin
      alloc_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) alloc_idx = IDX_W'(i);
      end
   end

   assign full = &valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         if (free_en) valid_q[free_idx] <= 1'b0;
         if (alloc)   valid_q[alloc_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) ent_q[alloc_idx] <= '{node: alloc_node, rtag: alloc_rtag,
                                       addr: alloc_addr, len: alloc_len};
   end

   assign look_valid = valid_q[look_idx];
   assign look_node  = ent_q[look_idx].node;
   assign look_rtag  = ent_q[look_idx].rtag;
   assign look_addr  = ent_q[look_idx].addr;
   assign look_len   = ent_q[look_idx].len;

   assert_alloc_not_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full);

   assert_alloc_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !free_en) |=> $countones(valid_q) == $past($countones(valid_q)) + 1);

   assert_free_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (free_en && !alloc) |=> !valid_q[$past(free_idx)]);

endmodule

// File: rtl/np_drop_log.sv
module np_drop_log #(
   parameter int NODE_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drop_en,
   input  logic [2:0]        drop_reason,
   input  logic [NODE_W-1:0] drop_node,
   output logic [CNT_W-1:0]  cnt,
   output logic [2:0]        reason,
   output logic [NODE_W-1:0] node
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         reason <= '0;
         node   <= '0;
      end else if (drop_en) begin
         if (cnt != '1) cnt <= cnt + 1'b1;
         reason <= drop_reason;
         node   <= drop_node;
      end
   end

   assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_en && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

   assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_en |=> $stable(cnt));

endmodule

// File: rtl/np_request_parser.sv
module np_request_parser
   import np_pkg::*;
#(
   parameter int DATA_W    = 512,
   parameter int NODE_W    = 16,
   parameter int ADDR_W    = 48,
   parameter logic [NODE_W-1:0] NODE_ID = NODE_W'(7),
   parameter int MAX_LEN   = 496,
   parameter int TAG_DEPTH = 8,
   parameter int CNT_W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic                         in_sop,
   input  logic                         in_eop,
   input  logic [DATA_W-1:0]            in_data,
   output logic                         out_valid,
   output logic                         out_first,
   output logic                         out_last,
   output logic [1:0]                   out_target,
   output logic [$clog2(TAG_DEPTH)-1:0] out_tag,
   output logic [DATA_W-1:0]            out_data,
   output logic                         notify_valid,
   output logic [NODE_W-1:0]            notify_node,
   output logic [7:0]                   notify_rtag,
   input  logic                         tag_free_valid,
   input  logic [$clog2(TAG_DEPTH)-1:0] tag_free_idx,
   input  logic [$clog2(TAG_DEPTH)-1:0] tag_look_idx,
   output logic                         tag_look_valid,
   output logic [NODE_W-1:0]            tag_look_node,
   output logic [7:0]                   tag_look_rtag,
   output logic [ADDR_W-1:0]            tag_look_addr,
   output logic [15:0]                  tag_look_len,
   output logic [CNT_W-1:0]             dbg_drop_cnt,
   output logic [2:0]                   dbg_reason,
   output logic [NODE_W-1:0]            dbg_node
);

   localparam int TAG_IW = $clog2(TAG_DEPTH);

   if (DATA_W < DESC_USED_W + 32) begin : g_bad_data_w
      $error("DATA_W too narrow for descriptor");
   end
   if (NODE_W < 1 || NODE_W > 32) begin : g_bad_node_w
      $error("NODE_W must be 1..32");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must be 8..64");
   end
   if (MAX_LEN < 16 || MAX_LEN > 65535 || (MAX_LEN % 16) != 0) begin : g_bad_max_len
      $error("MAX_LEN must be a multiple of 16 below 65536");
   end
   if (TAG_DEPTH < 2 || (1 << TAG_IW) != TAG_DEPTH) begin : g_bad_depth
      $error("TAG_DEPTH must be a power of two, at least 2");
   end

   pstate_e             state_q;
   logic [NODE_W-1:0]   dest_q;
   logic [NODE_W-1:0]   src_q;
   target_e             tgt_q;

   logic                chk_ok;
   reason_e             chk_reason;
   target_e             chk_target;
   logic                chk_read;
   logic                chk_notify;
   logic [7:0]          chk_rtag;
   logic [15:0]         chk_len;
   logic [ADDR_W-1:0]   chk_addr;

   logic                tm_full;
   logic [TAG_IW-1:0]   tm_idx;
   logic                tm_alloc;

   logic                hs;
   logic                in_desc;
   logic                desc_acc;
   logic                desc_drop;
   logic                fwd;

   np_desc_check #(
      .NODE_W  (NODE_W),
      .ADDR_W  (ADDR_W),
      .NODE_ID (NODE_ID),
      .MAX_LEN (MAX_LEN)
   ) i_check (
      .desc    (in_data[DESC_USED_W-1:0]),
      .dest    (dest_q),
      .ok      (chk_ok),
      .reason  (chk_reason),
      .target  (chk_target),
      .is_read (chk_read),
      .notify  (chk_notify),
      .rtag    (chk_rtag),
      .len     (chk_len),
      .addr    (chk_addr)
   );

   assign in_desc   = (state_q == ST_DESC);
   assign in_ready  = !(in_desc && in_valid && chk_ok && chk_read && tm_full);
   assign hs        = in_valid && in_ready;
   assign desc_acc  = hs && in_desc && chk_ok;
   assign desc_drop = hs && in_desc && !chk_ok;
   assign tm_alloc  = desc_acc && chk_read;
   assign fwd       = desc_acc || (hs && state_q == ST_BODY);

   np_tag_map #(
      .DEPTH  (TAG_DEPTH),
      .NODE_W (NODE_W),
      .ADDR_W (ADDR_W)
   ) i_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (tm_alloc),
      .alloc_node (src_q),
      .alloc_rtag (chk_rtag),
      .alloc_addr (chk_addr),
      .alloc_len  (chk_len),
      .alloc_idx  (tm_idx),
      .full       (tm_full),
      .free_en    (tag_free_valid),
      .free_idx   (tag_free_idx),
      .look_idx   (tag_look_idx),
      .look_valid (tag_look_valid),
      .look_node  (tag_look_node),
      .look_rtag  (tag_look_rtag),
      .look_addr  (tag_look_addr),
      .look_len   (tag_look_len)
   );

   np_drop_log #(
      .NODE_W (NODE_W),
      .CNT_W  (CNT_W)
   ) i_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .drop_en     (desc_drop),
      .drop_reason (chk_reason),
      .drop_node   (src_q),
      .cnt         (dbg_drop_cnt),
      .reason      (dbg_reason),
      .node        (dbg_node)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dest_q  <= '0;
         src_q   <= '0;
         tgt_q   <= TGT_NONE;
      end else if (hs) begin
         case (state_q)
            ST_IDLE: begin
               if (in_sop && !in_eop) begin
                  state_q <= ST_DESC;
                  dest_q  <= in_data[NODE_W-1:0];
                  src_q   <= in_data[SRC_LSB +: NODE_W];
               end
            end
            ST_DESC: begin
               if (in_eop)      state_q <= ST_IDLE;
               else if (chk_ok) state_q <= ST_BODY;
               else             state_q <= ST_DROP;
               if (chk_ok) tgt_q <= chk_target;
            end
            default: begin
               if (in_eop) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   target_e           out_tgt_q;
   logic [TAG_IW-1:0] out_tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_first    <= 1'b0;
         out_last     <= 1'b0;
         out_tgt_q    <= TGT_NONE;
         out_tag_q    <= '0;
         out_data     <= '0;
         notify_valid <= 1'b0;
         notify_node  <= '0;
         notify_rtag  <= '0;
      end else begin
         out_valid    <= fwd;
         notify_valid <= desc_acc && chk_notify;
         if (fwd) begin
            out_first <= in_desc;
            out_last  <= in_eop;
            out_tgt_q <= in_desc ? chk_target : tgt_q;
            out_tag_q <= tm_alloc ? tm_idx : '0;
            out_data  <= in_data;
         end
         if (desc_acc) begin
            notify_node <= src_q;
            notify_rtag <= chk_rtag;
         end
      end
   end

   assign out_target = out_tgt_q;
   assign out_tag    = out_tag_q;

   assert_notify_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid |-> (out_valid && out_first));

   assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DROP) |=> !out_valid);

   assert_stall_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> tm_full);

   assert_first_from_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_first) |-> $past(state_q) == ST_DESC);

   assert_target_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_tgt_q != TGT_NONE);

endmodule

// File: tb/test_np_request_parser.sv
module test_np_request_parser;

   localparam int DW    = 512;
   localparam int DEPTH = 4;
   localparam logic [15:0] MY_NODE = 16'h0005;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          in_valid = 0, in_sop = 0, in_eop = 0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready;
   logic          out_valid, out_first, out_last;
   logic [1:0]    out_target;
   logic [1:0]    out_tag;
   logic [DW-1:0] out_data;
   logic          notify_valid;
   logic [15:0]   notify_node;
   logic [7:0]    notify_rtag;
   logic          tag_free_valid = 0;
   logic [1:0]    tag_free_idx = '0;
   logic [1:0]    tag_look_idx = '0;
   logic          tag_look_valid;
   logic [15:0]   tag_look_node;
   logic [7:0]    tag_look_rtag;
   logic [47:0]   tag_look_addr;
   logic [15:0]   tag_look_len;
   logic [15:0]   dbg_drop_cnt;
   logic [2:0]    dbg_reason;
   logic [15:0]   dbg_node;

   np_request_parser #(
      .DATA_W(DW), .NODE_W(16), .ADDR_W(48), .NODE_ID(MY_NODE),
      .MAX_LEN(496), .TAG_DEPTH(DEPTH), .CNT_W(16)
   ) i_np_request_parser (
      .clk, .rst_n, .in_valid, .in_ready, .in_sop, .in_eop, .in_data,
      .out_valid, .out_first, .out_last, .out_target, .out_tag, .out_data,
      .notify_valid, .notify_node, .notify_rtag,
      .tag_free_valid, .tag_free_idx, .tag_look_idx, .tag_look_valid,
      .tag_look_node, .tag_look_rtag, .tag_look_addr, .tag_look_len,
      .dbg_drop_cnt, .dbg_reason, .dbg_node
   );

   int n_chk = 0;
   int n_err = 0;
   int seed  = 1;
   int exp_drops = 0;

   logic [DW-1:0] mon_d [16];
   logic          mon_first [16];
   logic          mon_last [16];
   logic [1:0]    mon_tgt [16];
   logic [1:0]    mon_tag [16];
   int            mon_n = 0;
   int            ntf_n = 0;
   logic [15:0]   ntf_node;
   logic [7:0]    ntf_rtag;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (mon_n < 16) begin
            mon_d[mon_n]     = out_data;
            mon_first[mon_n] = out_first;
            mon_last[mon_n]  = out_last;
            mon_tgt[mon_n]   = out_target;
            mon_tag[mon_n]   = out_tag;
         end
         mon_n++;
      end
      if (rst_n && notify_valid) begin
         ntf_n++;
         ntf_node = notify_node;
         ntf_rtag = notify_rtag;
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(int s, int i);
      return {16{32'(s * 131 + i * 7 + 1)}};
   endfunction

   function automatic logic [DW-1:0] sop_beat(logic [15:0] dest, logic [15:0] src);
      return {pat(seed, 99)[DW-1:64], 16'h0, src, 16'h0, dest};
   endfunction

   function automatic logic [DW-1:0] desc_beat(logic [3:0] cmd, logic [2:0] rsvd, logic ntf,
                                                logic [7:0] rtag, logic [15:0] len, logic [63:0] addr);
      return {pat(seed, 0)[DW-1:96], addr, len, rtag, rsvd, ntf, cmd};
   endfunction

   task automatic beat(logic sop, logic eop, logic [DW-1:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      @(posedge clk);
      @(posedge clk);
   endtask

   task automatic free_tag(logic [1:0] idx);
      @(negedge clk);
      tag_free_valid = 1'b1; tag_free_idx = idx;
      @(negedge clk);
      tag_free_valid = 1'b0;
      @(posedge clk);
   endtask

   // Sends one packet and checks every output against values worked out here.
   task automatic run_case(logic [15:0] dest, logic [15:0] src, logic [3:0] cmd, logic [2:0] rsvd,
                           logic ntf, logic [7:0] rtag, logic [15:0] len, logic [63:0] addr,
                           int nb, logic do_free, logic [1:0] exp_tag);
      logic [DW-1:0] exp_d [8];
      int reason;
      int tgt;
      int drops0;
      seed++;
      if (dest != MY_NODE) reason = 1;
      else if (cmd < 1 || cmd > 5 || rsvd != 0) reason = 2;
      else if (addr[3:0] != 0 || addr[63:48] != 0) reason = 3;
      else if (len == 0 || len % 16 != 0 || len > 496) reason = 4;
      else reason = 0;
      tgt = (cmd <= 2) ? 0 : (cmd <= 4) ? 1 : 2;
      mon_n = 0; ntf_n = 0;
      drops0 = int'(dbg_drop_cnt);
      exp_d[0] = desc_beat(cmd, rsvd, ntf, rtag, len, addr);
      for (int i = 1; i < 8; i++) exp_d[i] = pat(seed, i);
      beat(1'b1, 1'b0, sop_beat(dest, src));
      for (int i = 0; i < nb; i++) beat(1'b0, i == nb - 1, exp_d[i]);
      idle();
      if (reason == 0) begin
         exp_drops = exp_drops;
         chk("R3 beat count", 64'(mon_n), 64'(nb));
         chk("R2 first flag", 64'(mon_first[0]), 64'd1);
         chk("R2 descriptor data", 64'(mon_d[0] == exp_d[0]), 64'd1);
         for (int i = 1; i < nb; i++) begin
            chk("R3 body data", 64'(mon_d[i] == exp_d[i]), 64'd1);
            chk("R3 body not first", 64'(mon_first[i]), 64'd0);
            chk("R4 target held", 64'(mon_tgt[i]), 64'(tgt));
         end
         chk("R3 last flag", 64'(mon_last[nb-1]), 64'd1);
         chk("R4 target", 64'(mon_tgt[0]), 64'(tgt));
         chk("R12 notify count", 64'(ntf_n), 64'(ntf));
         if (ntf) begin
            chk("R12 notify node", 64'(ntf_node), 64'(src));
            chk("R12 notify rtag", 64'(ntf_rtag), 64'(rtag));
         end
         chk("R9 no drop counted", 64'(dbg_drop_cnt), 64'(drops0));
         if (cmd == 4'd2) begin
            chk("R10 tag index", 64'(mon_tag[0]), 64'(exp_tag));
            tag_look_idx = exp_tag;
            #1;
            chk("R10 lookup valid", 64'(tag_look_valid), 64'd1);
            chk("R10 lookup node", 64'(tag_look_node), 64'(src));
            chk("R10 lookup rtag", 64'(tag_look_rtag), 64'(rtag));
            chk("R10 lookup addr", 64'(tag_look_addr), addr);
            chk("R10 lookup len", 64'(tag_look_len), 64'(len));
            if (do_free) begin
               free_tag(exp_tag);
               #1;
               chk("R13 freed slot", 64'(tag_look_valid), 64'd0);
            end
         end
      end else begin
         exp_drops++;
         chk("R9 nothing forwarded", 64'(mon_n), 64'd0);
         chk("R12 no notify on drop", 64'(ntf_n), 64'd0);
         chk("R9 drop count", 64'(dbg_drop_cnt), 64'(drops0 + 1));
         chk("R9 drop node", 64'(dbg_node), 64'(src));
         case (reason)
            1: chk("R5 reason", 64'(dbg_reason), 64'd1);
            2: chk("R6 reason", 64'(dbg_reason), 64'd2);
            3: chk("R7 reason", 64'(dbg_reason), 64'd3);
            default: chk("R8 reason", 64'(dbg_reason), 64'd4);
         endcase
      end
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);

      // R1 reset state
      chk("R1 out_valid", 64'(out_valid), 64'd0);
      chk("R1 notify", 64'(notify_valid), 64'd0);
      chk("R1 in_ready", 64'(in_ready), 64'd1);
      chk("R1 drop count", 64'(dbg_drop_cnt), 64'd0);
      for (int i = 0; i < DEPTH; i++) begin
         tag_look_idx = 2'(i);
         #1;
         chk("R1 tag empty", 64'(tag_look_valid), 64'd0);
      end
      @(posedge clk);

      // R4 R6 R12: every command code, plus a reserved bit
      for (int c = 0; c < 16; c++)
         run_case(MY_NODE, 16'h0101, 4'(c), 3'd0, 1'b1, 8'(c + 16), 16'd64, 64'h1000, 2, 1'b1, 2'd0);
      for (int r = 1; r < 8; r++)
         run_case(MY_NODE, 16'h0102, 4'd1, 3'(r), 1'b0, 8'h11, 16'd32, 64'h2000, 1, 1'b1, 2'd0);

      // R8: every length 0..520
      for (int l = 0; l <= 520; l++) begin
         int nb;
         nb = (l > 48) ? 1 + (l - 48 + 63) / 64 : 1;
         if (nb > 8) nb = 8;
         run_case(MY_NODE, 16'h0203, 4'd1, 3'd0, 1'b0, 8'h22, 16'(l), 64'h40, nb, 1'b1, 2'd0);
      end

      // R7: every low address nibble, and upper address bits
      for (int a = 0; a < 16; a++)
         run_case(MY_NODE, 16'h0304, 4'd3, 3'd0, 1'b0, 8'h33, 16'd16, 64'h5500 + 64'(a), 1, 1'b1, 2'd0);
      run_case(MY_NODE, 16'h0304, 4'd1, 3'd0, 1'b0, 8'h33, 16'd16, 64'h1_0000_0000_0000, 1, 1'b1, 2'd0);
      run_case(MY_NODE, 16'h0304, 4'd1, 3'd0, 1'b0, 8'h33, 16'd16, 64'h0000_FFFF_FFFF_FFF0, 1, 1'b1, 2'd0);

      // R5 and priority: destinations, with other faults stacked
      for (int d = 0; d < 16; d++)
         run_case(16'(d), 16'h0405, 4'd5, 3'd0, 1'b0, 8'h44, 16'd48, 64'h80, 1, 1'b1, 2'd0);
      run_case(16'h0009, 16'h0406, 4'd9, 3'd0, 1'b0, 8'h44, 16'd3, 64'h81, 1, 1'b1, 2'd0);
      run_case(MY_NODE, 16'h0407, 4'd9, 3'd0, 1'b0, 8'h44, 16'd3, 64'h81, 2, 1'b1, 2'd0);
      run_case(MY_NODE, 16'h0408, 4'd2, 3'd0, 1'b0, 8'h44, 16'd3, 64'h81, 3, 1'b1, 2'd0);

      // R3 R10: largest read, eight beats, with notify
      run_case(MY_NODE, 16'h0509, 4'd2, 3'd0, 1'b1, 8'h5A, 16'd496, 64'h7700, 8, 1'b1, 2'd0);

      // R2: stray beat and single-beat start cell are ignored
      mon_n = 0;
      beat(1'b0, 1'b1, pat(77, 1));
      beat(1'b1, 1'b1, sop_beat(MY_NODE, 16'h0600));
      idle();
      chk("R2 stray beats no output", 64'(mon_n), 64'd0);
      chk("R2 stray beats no drop", 64'(dbg_drop_cnt), 64'(exp_drops));

      // R10 R11 R13: fill the tag table
      for (int t = 0; t < DEPTH; t++)
         run_case(MY_NODE, 16'(16'h0700 + t), 4'd2, 3'd0, 1'b0, 8'(t + 1),
                  16'(16 * (t + 1)), 64'(64'h9000 + 16 * t), 1, 1'b0, 2'(t));
      // a write and a failing read pass while full
      run_case(MY_NODE, 16'h0710, 4'd1, 3'd0, 1'b0, 8'h71, 16'd128, 64'hA000, 2, 1'b1, 2'd0);
      run_case(MY_NODE, 16'h0711, 4'd2, 3'd0, 1'b0, 8'h72, 16'd5, 64'hA000, 1, 1'b1, 2'd0);
      chk("R11 no stall on write or bad read", 64'(in_ready), 64'd1);

      // a good read while full stalls until slot 2 is freed
      seed++;
      mon_n = 0;
      beat(1'b1, 1'b0, sop_beat(MY_NODE, 16'h0720));
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1;
      in_data = desc_beat(4'd2, 3'd0, 1'b0, 8'h73, 16'd256, 64'hB000);
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R11 stalled", 64'(in_ready), 64'd0);
         @(negedge clk);
      end
      chk("R11 nothing forwarded while stalled", 64'(mon_n), 64'd0);
      tag_free_valid = 1'b1; tag_free_idx = 2'd2;
      @(negedge clk);
      tag_free_valid = 1'b0;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      idle();
      chk("R11 accepted after free", 64'(mon_n), 64'd1);
      chk("R13 reused slot", 64'(mon_tag[0]), 64'd2);
      tag_look_idx = 2'd2;
      #1;
      chk("R10 reused entry addr", 64'(tag_look_addr), 64'hB000);
      chk("R10 reused entry rtag", 64'(tag_look_rtag), 64'h73);
      tag_look_idx = 2'd1;
      #1;
      chk("R10 other entry kept", 64'(tag_look_len), 64'd32);
      for (int t = 0; t < DEPTH; t++) free_tag(2'(t));
      tag_look_idx = 2'd3;
      #1;
      chk("R13 all freed", 64'(tag_look_valid), 64'd0);
      run_case(MY_NODE, 16'h0730, 4'd2, 3'd0, 1'b1, 8'h74, 16'd16, 64'hC000, 1, 1'b1, 2'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule